// File: doc/BRIEF.md
# Multiplexed-Bus Memory Chip-Select Decoder

This block sits beside a small processor whose 16-bit memory address leaves the chip as two bytes on one 8-bit bus. The high byte comes first, marked by an address strobe. The low byte follows while the read or write strobe is active. The decoder holds the high byte in a register. It joins that byte with the low byte still on the bus to form the effective address. From that address it drives the chip selects for a console memory system. The system has a 1 KB system ROM at 0x0000, a 1 KB game ROM at 0x0400 that a plugged-in cartridge can switch off, and two 256-byte RAM banks.

Each ROM chip compares the latched high byte against its own base, at 1 KB granularity, and reports a hit. RAM is not decoded from a fixed window. It is enabled wherever no on-board ROM hits, address bit 9 is clear, and the cartridge does not claim the cycle. RAM therefore appears at 0x0800–0x09FF, again at 0x0C00–0x0DFF, and at every higher address whose bit 9 is 0. Addresses with bit 9 set and no ROM hit are left undriven for cartridge memory.

The ROM and RAM arrays are not part of the block. The read enables and the write enable it produces are used to control them.

Top module: `mem_csel`

## Requirements
- R1: After reset the latched high byte is 0x00. On a clock edge where `addr_stb` is 1 and was 0 at the previous edge, the high byte takes the value of `ad_bus`. At every other edge it holds, including while `addr_stb` stays high. `eff_addr` is {latched high byte, `ad_bus`}.
- R2: `rom_sel[0]` (system ROM) is 1 exactly when latched high-byte bits 7..2 equal 0, i.e. addresses 0x0000–0x03FF.
- R3: `rom_sel[1]` (game ROM) is 1 exactly when high-byte bits 7..2 equal 1 (0x0400–0x07FF) and `game_rom_en` is 1. With `game_rom_en` at 0 it never asserts.
- R4: RAM is selected only when no bit of `rom_sel` is 1, latched address bit 9 (high-byte bit 1) is 0, and `cart_claim` is 0.
- R5: When RAM is selected, latched address bit 8 (high-byte bit 0) picks the bank. The value 0 gives `ram_bank_sel`=2'b01 and the value 1 gives 2'b10. Otherwise `ram_bank_sel` is 2'b00.
- R6: `ram_rd` is 1 only while a bank is selected and `rd_n` is 0. `ram_wr` is 1 only while a bank is selected and `wr_n` is 0. A selected RAM with both strobes high neither reads nor writes.
- R7: RAM mirrors. With no cartridge claim, 0x0C00–0x0DFF reaches the same cells as 0x0800–0x09FF. Any address at or above 0x1000 with bit 9 clear does the same, for example 0xF1xx reaches bank 1.
- R8: With bit 9 set and no ROM hit (for example 0x0A00, 0x0E00, 0x33xx), no select is asserted, `rd_valid` stays 0, and a write strobe there changes no RAM cell.
- R9: `rom_rd[i]` equals `rom_sel[i]` while `rd_n` is 0, and is 0 otherwise.
- R10: `rd_valid` is 1 exactly when `rd_n` is 0 and an on-board ROM or RAM bank is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_bus | input | 8 | Multiplexed address bus: high byte during the strobe, low byte after |
| addr_stb | input | 1 | High-address strobe; its rising edge captures the high byte |
| rd_n | input | 1 | Active-low memory read strobe |
| wr_n | input | 1 | Active-low memory write strobe |
| game_rom_en | input | 1 | 1 enables the on-board game ROM; a cartridge pulls it to 0 |
| cart_claim | input | 1 | 1 when cartridge ROM decodes the current address |
| eff_addr | output | 16 | Effective address {latched high byte, ad_bus} |
| rom_sel | output | 2 | ROM chip selects, bit 0 system, bit 1 game |
| rom_rd | output | 2 | ROM output enables qualified by the read strobe |
| ram_bank_sel | output | 2 | RAM bank selects, one-hot or zero |
| ram_rd | output | 1 | RAM output enable |
| ram_wr | output | 1 | RAM write enable |
| rd_valid | output | 1 | An on-board device drives the data bus |

## Verification
The properties assume a bus protocol in which the read and write strobes are never both low, and the strobe edge is the only thing that moves the high byte. The bench keeps to this. Every access raises `addr_stb` for one clock with the high byte on the bus, then lowers it and presents the low byte with at most one strobe active. The one exception is an access that deliberately holds the strobe high for a second clock to show that this second clock captures nothing. Cartridge inputs change only in the low-byte phase, so the selects are steady at each sampling point. A bench RAM model, cleared at reset, makes writes and mirrored reads visible at the ports.

// File: rtl/msel_pkg.sv
package msel_pkg;

    localparam int BYTE_W     = 8;
    localparam int KB_DROP    = 2;               // high-byte bits below 1 KB
    localparam int KB_W       = BYTE_W - KB_DROP;
    localparam int N_BANK     = 2;
    localparam int SEL_BIT    = 1;               // address bit 9 inside the high byte
    localparam int BANK_BIT   = 0;               // address bit 8 inside the high byte

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [KB_W-1:0]   kb_t;

    typedef enum logic [0:0] {
        BANK_LOW  = 1'b0,
        BANK_HIGH = 1'b1
    } bank_e;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
    } maddr_t;

    typedef struct packed {
        logic  a9;
        bank_e bank;
        kb_t   kb;
    } hi_fields_t;

    function automatic hi_fields_t split_hi(input byte_t hi);
        hi_fields_t f;
        f.a9   = hi[SEL_BIT];
        f.bank = bank_e'(hi[BANK_BIT]);
        f.kb   = hi[BYTE_W-1:KB_DROP];
        return f;
    endfunction

endpackage

// File: rtl/msel_hi_latch.sv
module msel_hi_latch
    import msel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stb,
    input  byte_t bus,
    output byte_t hi_q
);
    logic stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b0;
            hi_q  <= '0;
        end else begin
            stb_q <= stb;
            if (stb && !stb_q)
                hi_q <= bus;
        end
    end
endmodule

// File: rtl/msel_rom_match.sv
module msel_rom_match
    import msel_pkg::*;
#(
    parameter kb_t KB_INDEX = '0
) (
    input  kb_t  kb,
    input  logic chip_en,
    output logic hit
);
    always_comb hit = chip_en && (kb == KB_INDEX);
endmodule

// File: rtl/msel_ram_select.sv
module msel_ram_select
    import msel_pkg::*;
(
    input  logic              rom_any,
    input  logic              a9,
    input  bank_e             bank,
    input  logic              cart_claim,
    output logic [N_BANK-1:0] bank_sel
);
    logic ram_en;

    // RAM is the complement of every other claimant
    always_comb ram_en = !(rom_any || a9 || cart_claim);

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        always_comb bank_sel[b] = ram_en && (int'(bank) == b);
    end
endmodule

// File: rtl/mem_csel.sv
module mem_csel
    import msel_pkg::*;
#(
    parameter int N_ROM     = 2,
    parameter int GAME_CHIP = 1,
    parameter logic [N_ROM*KB_W-1:0] ROM_KB_MAP = {6'd1, 6'd0}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        ad_bus,
    input  logic              addr_stb,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              game_rom_en,
    input  logic              cart_claim,
    output logic [15:0]       eff_addr,
    output logic [N_ROM-1:0]  rom_sel,
    output logic [N_ROM-1:0]  rom_rd,
    output logic [N_BANK-1:0] ram_bank_sel,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic              rd_valid
);
    byte_t      hi_q;
    hi_fields_t hf;
    maddr_t     ma;
    logic       rom_any;

    msel_hi_latch u_hi (
        .clk  (clk),
        .rst  (rst),
        .stb  (addr_stb),
        .bus  (ad_bus),
        .hi_q (hi_q)
    );

    always_comb begin
        hf       = split_hi(hi_q);
        ma.hi    = hi_q;
        ma.lo    = ad_bus;
        eff_addr = ma;
    end

    for (genvar i = 0; i < N_ROM; i++) begin : g_rom
        logic en_i;
        if (i == GAME_CHIP) begin : g_game
            always_comb en_i = game_rom_en;
        end else begin : g_fixed
            always_comb en_i = 1'b1;
        end
        msel_rom_match #(
            .KB_INDEX (ROM_KB_MAP[i*KB_W +: KB_W])
        ) u_match (
            .kb      (hf.kb),
            .chip_en (en_i),
            .hit     (rom_sel[i])
        );
    end

    always_comb begin
        rom_any = |rom_sel;
        rom_rd  = rom_sel & {N_ROM{!rd_n}};
    end

    msel_ram_select u_ram (
        .rom_any    (rom_any),
        .a9         (hf.a9),
        .bank       (hf.bank),
        .cart_claim (cart_claim),
        .bank_sel   (ram_bank_sel)
    );

    always_comb begin
        ram_rd   = (|ram_bank_sel) && !rd_n;
        ram_wr   = (|ram_bank_sel) && !wr_n;
        rd_valid = !rd_n && (rom_any || (|ram_bank_sel));
    end
endmodule

// File: rtl/mem_csel_chk.sv
module mem_csel_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  ad_bus,
    input logic        addr_stb,
    input logic        rd_n,
    input logic        wr_n,
    input logic        game_rom_en,
    input logic        cart_claim,
    input logic [15:0] eff_addr,
    input logic [1:0]  rom_sel,
    input logic [1:0]  rom_rd,
    input logic [1:0]  ram_bank_sel,
    input logic        ram_rd,
    input logic        ram_wr,
    input logic        rd_valid
);
    assert_hi_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (addr_stb && !$past(addr_stb)) |=> (eff_addr[15:8] == $past(ad_bus)));

    assert_game_off_R3: assert property (@(posedge clk) disable iff (rst)
        !game_rom_en |-> !rom_sel[1]);

    assert_ram_excl_R4: assert property (@(posedge clk) disable iff (rst)
        (|ram_bank_sel) |-> (rom_sel == 2'b00 && !cart_claim && !eff_addr[9]));

    assert_bank_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ram_bank_sel));

    assert_bank_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (|ram_bank_sel) |-> (ram_bank_sel[1] == eff_addr[8]));

    assert_ram_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (ram_rd |-> !rd_n) and (ram_wr |-> !wr_n));

    assert_a9_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (eff_addr[9] && rom_sel == 2'b00) |-> (ram_bank_sel == 2'b00 && !rd_valid));

    assert_rom_rd_R9: assert property (@(posedge clk) disable iff (rst)
        (|rom_rd) |-> (!rd_n && ((rom_rd & ~rom_sel) == 2'b00)));

    assert_valid_R10: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!rd_n && (|{rom_sel, ram_bank_sel})));
endmodule

bind mem_csel mem_csel_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ad_bus       (ad_bus),
    .addr_stb     (addr_stb),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .game_rom_en  (game_rom_en),
    .cart_claim   (cart_claim),
    .eff_addr     (eff_addr),
    .rom_sel      (rom_sel),
    .rom_rd       (rom_rd),
    .ram_bank_sel (ram_bank_sel),
    .ram_rd       (ram_rd),
    .ram_wr       (ram_wr),
    .rd_valid     (rd_valid)
);

// File: tb/mem_csel_bench.sv
module mem_csel_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ad_bus = 8'h00;
    logic        addr_stb = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        game_rom_en = 1'b1;
    logic        cart_claim = 1'b0;
    logic [15:0] eff_addr;
    logic [1:0]  rom_sel;
    logic [1:0]  rom_rd;
    logic [1:0]  ram_bank_sel;
    logic        ram_rd;
    logic        ram_wr;
    logic        rd_valid;
    logic [7:0]  wdata = 8'h00;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mem_csel u_mem_csel (
        .clk (clk), .rst (rst), .ad_bus (ad_bus), .addr_stb (addr_stb),
        .rd_n (rd_n), .wr_n (wr_n), .game_rom_en (game_rom_en),
        .cart_claim (cart_claim), .eff_addr (eff_addr), .rom_sel (rom_sel),
        .rom_rd (rom_rd), .ram_bank_sel (ram_bank_sel), .ram_rd (ram_rd),
        .ram_wr (ram_wr), .rd_valid (rd_valid)
    );

    // behavioural RAM controlled only by the decoder's outputs
    logic [7:0] ram_mem [0:511];
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 512; k++) ram_mem[k] <= 8'h00;
        end else if (ram_wr) begin
            ram_mem[{ram_bank_sel[1], ad_bus}] <= wdata;
        end
    end
    logic [7:0] rdata;
    always_comb rdata = ram_mem[{ram_bank_sel[1], ad_bus}];

    // reference copy updated from the requirements
    logic [7:0] ref_mem [0:511];
    initial for (int k = 0; k < 512; k++) ref_mem[k] = 8'h00;

    typedef struct {
        logic [15:0] eff;
        logic [1:0]  rsel;
        logic [1:0]  rrd;
        logic [1:0]  bank;
        logic        mrd;
        logic        mwr;
        logic        val;
        bit          chk_data;
        logic [7:0]  data;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic access(input logic [7:0] hi, input logic [7:0] lo,
                          input logic rdn, input logic wrn,
                          input logic en, input logic cart,
                          input logic [7:0] wd, input bit hold,
                          input string tag);
        exp_t e;
        logic sys_h, game_h, ram_h;
        @(posedge clk); #1;
        rd_n = 1'b1; wr_n = 1'b1;
        ad_bus = hi; addr_stb = 1'b1;
        if (hold) begin
            @(posedge clk); #1;
            ad_bus = ~hi;          // second strobe-high edge must not capture
        end
        @(posedge clk); #1;
        addr_stb = 1'b0; ad_bus = lo;
        rd_n = rdn; wr_n = wrn; game_rom_en = en; cart_claim = cart; wdata = wd;
        sys_h  = (hi[7:2] == 6'd0);
        game_h = (hi[7:2] == 6'd1) && en;
        ram_h  = !(sys_h || game_h) && !hi[1] && !cart;
        e.eff  = {hi, lo};
        e.rsel = {game_h, sys_h};
        e.rrd  = {game_h, sys_h} & {2{!rdn}};
        e.bank = ram_h ? (hi[0] ? 2'b10 : 2'b01) : 2'b00;
        e.mrd  = ram_h && !rdn;
        e.mwr  = ram_h && !wrn;
        e.val  = !rdn && (sys_h || game_h || ram_h);
        e.chk_data = e.mrd;
        e.data = ref_mem[{hi[0], lo}];
        e.tag  = tag;
        if (e.mwr) ref_mem[{hi[0], lo}] = wd;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare outputs against the queued expectation
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb_q.pop_front();
            bad = (eff_addr !== e.eff) || (rom_sel !== e.rsel) || (rom_rd !== e.rrd) ||
                  (ram_bank_sel !== e.bank) || (ram_rd !== e.mrd) || (ram_wr !== e.mwr) ||
                  (rd_valid !== e.val) || (e.chk_data && rdata !== e.data);
            n_chk++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s: got addr=%h rom=%b rrd=%b bank=%b rd=%b wr=%b v=%b d=%h exp addr=%h rom=%b rrd=%b bank=%b rd=%b wr=%b v=%b d=%h",
                         e.tag, eff_addr, rom_sel, rom_rd, ram_bank_sel, ram_rd, ram_wr,
                         rd_valid, rdata, e.eff, e.rsel, e.rrd, e.bank, e.mrd, e.mwr,
                         e.val, e.data);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state: high byte 0, so address 0x0000 hits system ROM
        n_chk++;
        if (eff_addr !== 16'h0000 || rom_sel !== 2'b01) begin
            n_fail++;
            $display("FAIL R1 reset: got addr=%h rom=%b exp addr=0000 rom=01", eff_addr, rom_sel);
        end
        access(8'h00, 8'h12, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R2 sys rom");
        access(8'h03, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R2 sys top");
        access(8'h04, 8'h56, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R3 game rom");
        access(8'h07, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R9 game no rd");
        access(8'h04, 8'h56, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, "R3 game off cart");
        access(8'h05, 8'h20, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R4 game off ram");
        access(8'h08, 8'h05, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b0, "R6 write bank0");
        access(8'h09, 8'h05, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0, "R5 write bank1");
        access(8'h0C, 8'h05, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R7 mirror 0C05");
        access(8'hF1, 8'h05, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R7 mirror F105");
        access(8'h08, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R6 no strobe");
        access(8'h08, 8'h05, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, "R4 cart claim");
        access(8'h0A, 8'h10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R8 0A10 empty");
        access(8'h0E, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R8 0E00 empty");
        access(8'h12, 8'h34, 1'b1, 1'b0, 1'b1, 1'b0, 8'hEE, 1'b0, "R8 write ignored");
        access(8'h08, 8'h34, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R8 cell unchanged");
        access(8'h0D, 8'h05, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R10 read bank1");
        access(8'h09, 8'h77, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, "R1 held strobe");
        access(8'h33, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R10 nothing");
        @(negedge clk);
        finish_run();
    end
endmodule